// File: doc/BRIEF.md
# Horn-Schunck Velocity Update Datapath

This block performs one iteration of the Horn-Schunck velocity refinement for a single pixel on every clock. Its inputs are the three brightness gradients of the pixel (horizontal, vertical and temporal), the neighbourhood-averaged velocity pair from the previous iteration, and the smoothness weight (alpha squared). Its output is the refined velocity pair. The upstream gradient stage and the averaging line buffers are outside the block and feed it one pixel per clock. The outputs go back into the averaging stage for the next iteration.

Products and sums use exact integer arithmetic. The block performs one division per pixel, and the same quotient corrects both velocity components. The quotient keeps eight fractional bits and is not truncated to an integer. A restoring radix-2 divider computes it, one quotient bit per pipeline stage, so the block accepts a new pixel every cycle. A guard on the divisor replaces the quotient with zero when the divisor is zero. Every final value saturates instead of wrapping.

Top module: `hsFlowUpdate`

## Requirements
- R1: Number formats. `gradX`, `gradY` and `gradT` are signed 9-bit two's-complement integers. `uAvg`, `vAvg`, `uOut` and `vOut` are signed 16-bit values with 8 fractional bits, so the real value is the raw code divided by 256. `alphaSq` is an unsigned 16-bit integer.
- R2: The raw numerator is N = gradX*uAvg + gradY*vAvg + 256*gradT and the divisor is D = alphaSq + gradX² + gradY². The raw quotient code is N/D, truncated toward zero.
- R3: `uOut` = uAvg − gradX*q and `vOut` = vAvg − gradY*q, in raw codes. The same quotient code q is used for both components.
- R4: When D is zero, q is 0, so `uOut` equals `uAvg` and `vOut` equals `vAvg`.
- R5: `uOut` and `vOut` saturate to the range −32768..32767 instead of wrapping.
- R6: `outValid` rises exactly 29 clocks after the edge that captured a pixel with `inValid` high. Pixels presented on consecutive clocks come out on consecutive clocks.
- R7: While `rst` is high, and after it falls until the first accepted pixel has reached the output, `outValid` is 0. Pixels that were in flight when reset arrived never appear.
- R8: A cycle with `inValid` low produces a cycle with `outValid` low at the matching output slot. Its data does not disturb the neighbouring results.
- R9: The quotient code q saturates to −32768..32767 before it is used in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| inValid | input | 1 | The pixel on the inputs this cycle is to be processed |
| gradX | input | 9 | Horizontal brightness gradient, signed integer |
| gradY | input | 9 | Vertical brightness gradient, signed integer |
| gradT | input | 9 | Temporal brightness gradient, signed integer |
| uAvg | input | 16 | Averaged horizontal velocity, signed, 8 fractional bits |
| vAvg | input | 16 | Averaged vertical velocity, signed, 8 fractional bits |
| alphaSq | input | 16 | Smoothness weight, unsigned integer |
| outValid | output | 1 | `uOut` and `vOut` hold a result |
| uOut | output | 16 | Refined horizontal velocity, signed, 8 fractional bits |
| vOut | output | 16 | Refined vertical velocity, signed, 8 fractional bits |

## Verification
A corrupted remainder or quotient bit in a divider stage changes the shared quotient. The error then appears in both `uOut` and `vOut` together, 29 clocks after the affected pixel, and scaled by each gradient. A slip in the valid pipeline shows at once as `outValid` one slot early or late, or as a phantom or missing result in a run that contains bubbles. A broken zero guard or saturation stage shows only for the corner pixels: D of zero, a divisor of one, or large opposing gradients. The reference model therefore compares the outputs on every cycle, with directed pixels for these cases mixed into random streams.

// File: rtl/hsPkg.sv
`timescale 1ns/1ps
package hsPkg;
  // Enables issued by the control to the datapath pipeline registers.
  typedef struct packed {
    logic frontEn;  // capture numerator and divisor
    logic quoEn;    // capture the saturated quotient
    logic outEn;    // capture the final velocities
  } hsStrobes_t;
endpackage

// File: rtl/hsDivStep.sv
`timescale 1ns/1ps
// One restoring radix-2 step: bring down one dividend bit and try to subtract.
module hsDivStep #(
  parameter int DW = 19
) (
  input  logic [DW-1:0] remIn,
  input  logic [DW-1:0] den,
  input  logic          nextBit,
  output logic [DW-1:0] remOut,
  output logic          fits
);
  logic [DW:0] trial;

  always_comb begin
    trial  = {remIn, nextBit};
    fits   = (trial >= {1'b0, den});
    remOut = fits ? DW'(trial - {1'b0, den}) : trial[DW-1:0];
  end
endmodule

// File: rtl/hsCtrl.sv
`timescale 1ns/1ps
module hsCtrl
  import hsPkg::*;
#(
  parameter int LAT = 29
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  output hsStrobes_t strobes,
  output logic       outValid
);
  localparam int CW = $clog2(LAT + 2);

  logic [LAT-1:0] validPipe;

  always_ff @(posedge clk) begin
    if (rst) validPipe <= '0;
    else     validPipe <= {validPipe[LAT-2:0], inValid};
  end

  assign strobes.frontEn = inValid;
  assign strobes.quoEn   = validPipe[LAT-3];
  assign strobes.outEn   = validPipe[LAT-2];
  assign outValid        = validPipe[LAT-1];

  // Count of accepted pixels not yet delivered, for the checks below.
  logic [CW-1:0] inFlight;
  always_ff @(posedge clk) begin
    if (rst) inFlight <= '0;
    else     inFlight <= inFlight + CW'(inValid) - CW'(outValid);
  end

  // R6
  in_flight_bound_chk: assert property (@(posedge clk) disable iff (rst)
    inFlight <= CW'(LAT));

  // R8
  no_phantom_out_chk: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (inFlight != '0));
endmodule

// File: rtl/hsDatapath.sv
`timescale 1ns/1ps
module hsDatapath
  import hsPkg::*;
#(
  parameter int GW = 9,
  parameter int VW = 16,
  parameter int FB = 8,
  parameter int AW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  hsStrobes_t           strobes,
  input  logic signed [GW-1:0] gradX,
  input  logic signed [GW-1:0] gradY,
  input  logic signed [GW-1:0] gradT,
  input  logic signed [VW-1:0] uAvg,
  input  logic signed [VW-1:0] vAvg,
  input  logic        [AW-1:0] alphaSq,
  output logic signed [VW-1:0] uOut,
  output logic signed [VW-1:0] vOut
);
  localparam int PW   = GW + VW + 2;      // signed numerator width
  localparam int MW   = PW - 1;           // numerator magnitude bits = divider stages
  localparam int DW   = 2 * GW + 1;       // unsigned divisor width
  localparam int HI_I = (1 << (VW - 1)) - 1;
  localparam int LO_I = -(1 << (VW - 1));

  typedef struct packed {
    logic signed [PW-1:0] num;
    logic        [DW-1:0] den;
    logic signed [GW-1:0] gx, gy;
    logic signed [VW-1:0] ua, va;
  } front_t;

  typedef struct packed {
    logic                 neg, zero;
    logic signed [GW-1:0] gx, gy;
    logic signed [VW-1:0] ua, va;
  } side_t;

  typedef struct packed {
    logic signed [VW-1:0] quo;
    logic signed [GW-1:0] gx, gy;
    logic signed [VW-1:0] ua, va;
  } corr_t;

  function automatic logic signed [VW-1:0] satV(input logic signed [PW-1:0] x);
    if (x > PW'(HI_I))      return VW'(HI_I);
    else if (x < PW'(LO_I)) return VW'(LO_I);
    else                    return VW'(x);
  endfunction

  // Front stage: exact integer numerator and divisor.
  logic signed [PW-1:0] numAcc, sqX, sqY;
  logic        [DW-1:0] denAcc;
  front_t               frontQ;

  always_comb begin
    numAcc = PW'(gradX) * PW'(uAvg) + PW'(gradY) * PW'(vAvg) + (PW'(gradT) <<< FB);
    sqX    = PW'(gradX) * PW'(gradX);
    sqY    = PW'(gradY) * PW'(gradY);
    denAcc = DW'(alphaSq) + DW'(sqX) + DW'(sqY);
  end

  always_ff @(posedge clk) begin
    if (strobes.frontEn) begin
      frontQ.num <= numAcc;
      frontQ.den <= denAcc;
      frontQ.gx  <= gradX;
      frontQ.gy  <= gradY;
      frontQ.ua  <= uAvg;
      frontQ.va  <= vAvg;
    end
  end

  // Divider entry: sign and magnitude split, zero guard flag.
  logic [MW-1:0] headMag;
  side_t         headSide;
  always_comb begin
    headMag       = MW'(frontQ.num[PW-1] ? -frontQ.num : frontQ.num);
    headSide.neg  = frontQ.num[PW-1];
    headSide.zero = (frontQ.den == '0);
    headSide.gx   = frontQ.gx;
    headSide.gy   = frontQ.gy;
    headSide.ua   = frontQ.ua;
    headSide.va   = frontQ.va;
  end

  // Radix-2 divider chain, one quotient bit per stage.
  logic [DW-1:0] remNx [0:MW-1];
  logic          fitNx [0:MW-1];
  logic [DW-1:0] remQ  [1:MW];
  logic [MW-1:0] numQ  [1:MW-1];
  logic [MW-1:0] quoQ  [1:MW];
  logic [DW-1:0] denQ  [1:MW];
  side_t         sideQ [1:MW];

  for (genvar k = 0; k < MW; k++) begin : gDiv
    if (k == 0) begin : gHead
      hsDivStep #(.DW(DW)) step_i (
        .remIn(DW'(0)), .den(frontQ.den), .nextBit(headMag[MW-1]),
        .remOut(remNx[k]), .fits(fitNx[k]));
    end else begin : gBody
      hsDivStep #(.DW(DW)) step_i (
        .remIn(remQ[k]), .den(denQ[k]), .nextBit(numQ[k][MW-1]),
        .remOut(remNx[k]), .fits(fitNx[k]));
    end
  end

  always_ff @(posedge clk) begin
    remQ[1]  <= remNx[0];
    quoQ[1]  <= MW'(fitNx[0]);
    numQ[1]  <= headMag << 1;
    denQ[1]  <= frontQ.den;
    sideQ[1] <= headSide;
    for (int k = 1; k < MW; k++) begin
      remQ[k+1]  <= remNx[k];
      quoQ[k+1]  <= {quoQ[k][MW-2:0], fitNx[k]};
      denQ[k+1]  <= denQ[k];
      sideQ[k+1] <= sideQ[k];
    end
    for (int k = 1; k < MW - 1; k++) numQ[k+1] <= numQ[k] << 1;
  end

  // Quotient stage: sign restore, zero guard, saturation to the velocity format.
  logic signed [VW-1:0] quoSat;
  corr_t                corrQ;

  always_comb begin
    if (sideQ[MW].zero)                  quoSat = '0;
    else if (sideQ[MW].neg) begin
      if (quoQ[MW] > MW'(-LO_I))         quoSat = VW'(LO_I);
      else                               quoSat = -VW'(quoQ[MW]);
    end else begin
      if (quoQ[MW] > MW'(HI_I))          quoSat = VW'(HI_I);
      else                               quoSat = VW'(quoQ[MW]);
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.quoEn) begin
      corrQ.quo <= quoSat;
      corrQ.gx  <= sideQ[MW].gx;
      corrQ.gy  <= sideQ[MW].gy;
      corrQ.ua  <= sideQ[MW].ua;
      corrQ.va  <= sideQ[MW].va;
    end
  end

  // Output stage: shared quotient applied to both components, saturated.
  logic signed [PW-1:0] uWide, vWide;
  always_comb begin
    uWide = PW'(corrQ.ua) - PW'(corrQ.gx) * PW'(corrQ.quo);
    vWide = PW'(corrQ.va) - PW'(corrQ.gy) * PW'(corrQ.quo);
  end

  always_ff @(posedge clk) begin
    if (strobes.outEn) begin
      uOut <= satV(uWide);
      vOut <= satV(vWide);
    end
  end

  // R2
  rem_below_den_chk: assert property (@(posedge clk) disable iff (rst)
    (strobes.quoEn && !sideQ[MW].zero) |-> (remQ[MW] < denQ[MW]));

  // R4
  zero_den_quo_chk: assert property (@(posedge clk) disable iff (rst)
    (strobes.quoEn && sideQ[MW].zero) |=> (corrQ.quo == '0));

  // R3
  zero_quo_passthru_chk: assert property (@(posedge clk) disable iff (rst)
    (strobes.outEn && corrQ.quo == '0) |=>
      (uOut == $past(corrQ.ua) && vOut == $past(corrQ.va)));
endmodule

// File: rtl/hsFlowUpdate.sv
`timescale 1ns/1ps
module hsFlowUpdate
  import hsPkg::*;
#(
  parameter int GW = 9,
  parameter int VW = 16,
  parameter int FB = 8,
  parameter int AW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 inValid,
  input  logic signed [GW-1:0] gradX,
  input  logic signed [GW-1:0] gradY,
  input  logic signed [GW-1:0] gradT,
  input  logic signed [VW-1:0] uAvg,
  input  logic signed [VW-1:0] vAvg,
  input  logic        [AW-1:0] alphaSq,
  output logic                 outValid,
  output logic signed [VW-1:0] uOut,
  output logic signed [VW-1:0] vOut
);
  // front stage + one stage per magnitude bit + quotient stage + output stage
  localparam int LAT = 1 + (GW + VW + 1) + 1 + 1;

  hsStrobes_t strobes;

  hsCtrl #(.LAT(LAT)) ctrl_i (
    .clk(clk), .rst(rst), .inValid(inValid),
    .strobes(strobes), .outValid(outValid));

  hsDatapath #(.GW(GW), .VW(VW), .FB(FB), .AW(AW)) dp_i (
    .clk(clk), .rst(rst), .strobes(strobes),
    .gradX(gradX), .gradY(gradY), .gradT(gradT),
    .uAvg(uAvg), .vAvg(vAvg), .alphaSq(alphaSq),
    .uOut(uOut), .vOut(vOut));
endmodule

// File: tb/hsFlowUpdate_tb_top.sv
`timescale 1ns/1ps
module hsFlowUpdate_tb_top;
  localparam int LAT = 29;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic signed [8:0]  gradX = '0, gradY = '0, gradT = '0;
  logic signed [15:0] uAvg = '0, vAvg = '0;
  logic        [15:0] alphaSq = '0;
  logic               outValid;
  logic signed [15:0] uOut, vOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct { bit v; int u; int w; string tag; } exp_t;
  exp_t expq[$];

  hsFlowUpdate dut_i (
    .clk(clk), .rst(rst), .inValid(inValid),
    .gradX(gradX), .gradY(gradY), .gradT(gradT),
    .uAvg(uAvg), .vAvg(vAvg), .alphaSq(alphaSq),
    .outValid(outValid), .uOut(uOut), .vOut(vOut));

  always #10 clk = ~clk;

  function automatic longint sat16(input longint x);
    if (x > 32767)  return 32767;
    if (x < -32768) return -32768;
    return x;
  endfunction

  function automatic void model(input longint gx, gy, gt, ua, va, al,
                                output int eu, output int ev);
    longint n, d, q;
    n = gx * ua + gy * va + 256 * gt;
    d = al + gx * gx + gy * gy;
    q = (d == 0) ? 0 : sat16(n / d);
    eu = int'(sat16(ua - gx * q));
    ev = int'(sat16(va - gy * q));
  endfunction

  task automatic prefill(input string tag);
    exp_t e;
    expq.delete();
    e.v = 0; e.u = 0; e.w = 0; e.tag = tag;
    for (int i = 0; i < LAT - 1; i++) expq.push_back(e);
  endtask

  task automatic step(input bit vld, input int gx, gy, gt, ua, va, al, input string tag);
    exp_t e, c;
    inValid = vld;
    gradX = gx[8:0]; gradY = gy[8:0]; gradT = gt[8:0];
    uAvg = ua[15:0]; vAvg = va[15:0]; alphaSq = al[15:0];
    e.v = vld; e.tag = tag;
    model(gx, gy, gt, ua, va, al, e.u, e.w);
    expq.push_back(e);
    @(posedge clk);
    @(negedge clk);
    c = expq.pop_front();
    checks++;
    if (outValid !== c.v) begin
      errors++;
      $display("FAIL %s outValid actual %0b expected %0b", c.tag, outValid, c.v);
    end else if (c.v) begin
      checks++;
      if (int'(uOut) != c.u || int'(vOut) != c.w) begin
        errors++;
        $display("FAIL %s u/v actual %0d/%0d expected %0d/%0d",
                 c.tag, int'(uOut), int'(vOut), c.u, c.w);
      end
    end
  endtask

  task automatic doReset();
    rst = 1'b1; inValid = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    checks++;
    if (outValid !== 1'b0) begin
      errors++;
      $display("FAIL R7 outValid during reset actual %0b expected 0", outValid);
    end
    rst = 1'b0;
    prefill("R7");
  endtask

  function automatic int rs9();
    int r = $urandom;
    return int'($signed(r[8:0]));
  endfunction

  function automatic int rs16();
    int r = $urandom;
    return int'($signed(r[15:0]));
  endfunction

  function automatic int ru16();
    int r = $urandom;
    return int'({16'd0, r[15:0]});
  endfunction

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL R6 watchdog actual hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    doReset();

    // R1: fractional velocity codes with small gradients
    step(1, 3, -2, 10, 384, -128, 100, "R1");
    step(1, -7, 5, -3, -640, 77, 20, "R1");
    // R2: numerator and divisor combinations
    step(1, 100, -50, 37, 1000, 2000, 500, "R2");
    step(1, -255, 255, -256, -32768, 32767, 65535, "R2");
    step(1, 1, 1, 1, 1, 1, 0, "R2");
    // R3: one shared quotient, opposite gradient signs
    step(1, 20, -20, 64, 5000, 5000, 10, "R3");
    step(1, 0, 9, -40, 300, -300, 1, "R3");
    // R4: zero divisor passes the averages through
    step(1, 0, 0, 50, 1234, -999, 0, "R4");
    step(1, 0, 0, -256, -32768, 32767, 0, "R4");
    // R9: quotient clamps high and low with a divisor of one
    step(1, 1, 0, 255, 32767, 42, 0, "R9");
    step(1, -1, 0, -256, 32767, -42, 0, "R9");
    // R5: output clamps high and low
    step(1, 1, 255, 255, 32767, -32768, 0, "R5");
    step(1, -1, 255, -255, -32768, -32768, 0, "R5");
    for (int i = 0; i < LAT; i++) step(0, 0, 0, 0, 0, 0, 0, "R8");

    // R6: back-to-back random stream
    for (int i = 0; i < 400; i++)
      step(1, rs9(), rs9(), rs9(), rs16(), rs16(), ru16(), "R6");

    // R8: random stream with bubbles, small weights to exercise clamping
    for (int i = 0; i < 400; i++) begin
      int r = $urandom;
      step(r[1:0] != 2'b00, rs9(), rs9(), rs9(), rs16(), rs16(), int'(r[9:2]) & 8'hff, "R8");
    end

    // R7: reset with pixels in flight, then traffic again
    for (int i = 0; i < 10; i++)
      step(1, rs9(), rs9(), rs9(), rs16(), rs16(), ru16(), "R6");
    doReset();
    for (int i = 0; i < 40; i++)
      step(1, rs9(), rs9(), rs9(), rs16(), rs16(), ru16(), "R7");
    for (int i = 0; i < LAT; i++) step(0, 0, 0, 0, 0, 0, 0, "R8");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule